// File: doc/BRIEF.md
# Configurable memory read-error detector

This block watches data read back from a 16-bit memory and judges it against the check bits stored beside it. A small control register picks one of three modes: off, single-bit parity (even or odd sense), or a six-bit error-detecting Hamming code. The same mode also sets how the check bits for a memory write are formed. Those bits are produced combinationally from the write data, so the memory controller stores them with each word.

Every check is started by a read-valid strobe. Its verdict appears on registered outputs for exactly the next cycle. The shared status pin changes meaning with the mode. In off and parity modes it is an active-low parity-error line. In Hamming mode it becomes an active-high RAM-disable request, which tells an external correction unit that a word cannot be repaired. A separate active-high flag reports correctable single errors in Hamming mode. The block only detects errors. It does not correct data.

The mode is held in an enumerated state register with three states: `MODE_OFF`, `MODE_PAR` and `MODE_EDAC`. A configuration write moves it to the state its field selects: OFF to PAR, OFF to EDAC, PAR to EDAC, EDAC to PAR, and any state to OFF. With no configuration write the state does not change. The reset state is `MODE_OFF`.

Top module: `mem_err_detect`

## Requirements
- R1: After reset the mode is off, `mem_err_pin` is high, `single_err` is low and `wr_check` is all zero.
- R2: When `cfg_we` is high at a clock edge, `cfg_mode` sets the mode from the next cycle: 2'b00 off, 2'b01 parity, 2'b10 Hamming, 2'b11 off. `cfg_odd` set to 1 selects odd parity and 0 selects even parity. A read strobed in the same cycle as a configuration write is judged under the old mode.
- R3: In off mode no read raises any error indication, and `wr_check` is zero.
- R4: In parity mode, `wr_check[0]` is the XOR of the 16 write-data bits for even parity and its inverse for odd parity. `wr_check[5:1]` are zero.
- R5: In parity mode, `mem_err_pin` is low for exactly the cycle after a strobed read when the XOR of `rd_data` and `rd_check[0]` differs from `cfg_odd`. `rd_check[5:1]` are ignored.
- R6: In Hamming mode, data bit k (LSB first) takes the k-th codeword position in 1, 2, 3, … that is not a power of two, so it lands in positions 3..21. `wr_check[i]` for i = 0..4 is the XOR of the data bits whose position has bit i set. `wr_check[5]` is the XOR of all 16 data bits and `wr_check[4:0]`.
- R7: In Hamming mode, `single_err` is high for exactly the cycle after a strobed read whose 22 bits (data plus check) have odd overall parity. This covers a flip of any single bit, including `wr_check[5]`.
- R8: In Hamming mode, `mem_err_pin` (RAM disable) is high for exactly the cycle after a strobed read that has a nonzero 5-bit syndrome and even overall parity. The syndrome is the recomputed Hamming bits XOR `rd_check[4:0]`. `single_err` stays low for that read.
- R9: The idle level of `mem_err_pin` is high in off and parity modes and low in Hamming mode.
- R10: Without `rd_valid`, the read inputs cause no error indication, whatever their content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_mode | input | 2 | Mode field written on `cfg_we` |
| cfg_odd | input | 1 | Parity sense written on `cfg_we` (1 = odd) |
| wr_data | input | 16 | Data about to be written to memory |
| wr_check | output | 6 | Check bits for `wr_data` under the current mode |
| rd_valid | input | 1 | Read data and check bits are valid this cycle |
| rd_data | input | 16 | Data read from memory |
| rd_check | input | 6 | Check bits read from memory |
| mem_err_pin | output | 1 | Parity error (active low) or, in Hamming mode, RAM disable (active high) |
| single_err | output | 1 | Correctable single error in Hamming mode (active high) |

## Verification
Parity reads are tried with clean and corrupted words under both even and odd sense, and with the upper check bits scrambled, to show that the sense bit and the ignored bits are honoured. Hamming reads are tried with clean codewords, with one flipped data bit, one flipped Hamming bit and a flipped overall bit, and with two flips. These cases separate the single-error flag from the RAM-disable pulse. Corrupted words presented without the strobe, and a write of the reserved mode value, show that no verdict appears without a strobed read and that the reserved value falls back to off.

// File: rtl/med_pkg.sv
package med_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_PAR  = 2'b01,
        MODE_EDAC = 2'b10
    } med_mode_e;

    // Smallest r with 2**r >= data width + r + 1
    function automatic int ham_bits(input int dw);
        int r;
        r = 1;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    // Codeword position (1-based) of data bit idx, skipping powers of two
    function automatic int data_pos(input int idx);
        int p;
        int seen;
        p    = 0;
        seen = -1;
        while (seen < idx) begin
            p++;
            if ((p & (p - 1)) != 0) seen++;
        end
        return p;
    endfunction

endpackage

// File: rtl/med_hamming.sv
module med_hamming #(
    parameter int DATA_W = 16,
    parameter int HAM_W  = 5
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [HAM_W-1:0]  ham_o
);

    logic [HAM_W-1:0] term [DATA_W];

    for (genvar g = 0; g < DATA_W; g++) begin : g_term
        localparam int               POS   = med_pkg::data_pos(g);
        localparam logic [HAM_W-1:0] POS_V = HAM_W'(POS);
        assign term[g] = data_i[g] ? POS_V : '0;
    end

    always_comb begin
        ham_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            ham_o = ham_o ^ term[i];
        end
    end

endmodule

// File: rtl/med_ctrl.sv
module med_ctrl
    import med_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we,
    input  logic [1:0] cfg_mode,
    input  logic      cfg_odd,
    input  logic      rd_valid,
    input  logic      par_bad,
    input  logic      syn_nz,
    input  logic      ovr_odd,
    output med_mode_e mode_o,
    output logic      odd_o,
    output logic      perr_q,
    output logic      single_q,
    output logic      dbl_q
);

    med_mode_e state_q;
    med_mode_e state_d;
    logic      odd_q;

    // Next-state selection from the configuration write
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            unique case (cfg_mode)
                2'b01:   state_d = MODE_PAR;
                2'b10:   state_d = MODE_EDAC;
                2'b00:   state_d = MODE_OFF;
                2'b11:   state_d = MODE_OFF;
                default: state_d = MODE_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_OFF;
            odd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_we) odd_q <= cfg_odd;
        end
    end

    // Registered verdict for one cycle after a strobed read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_q   <= 1'b0;
            single_q <= 1'b0;
            dbl_q    <= 1'b0;
        end else begin
            perr_q   <= 1'b0;
            single_q <= 1'b0;
            dbl_q    <= 1'b0;
            if (rd_valid) begin
                unique case (state_q)
                    MODE_OFF:  ;
                    MODE_PAR:  perr_q <= par_bad;
                    MODE_EDAC: begin
                        single_q <= ovr_odd;
                        dbl_q    <= syn_nz & ~ovr_odd;
                    end
                    default:   ;
                endcase
            end
        end
    end

    assign mode_o = state_q;
    assign odd_o  = odd_q;

    assert_quiet_without_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !(perr_q || single_q || dbl_q));

    assert_single_double_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(single_q && dbl_q));

    assert_reserved_mode_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_mode == 2'b11) |=> state_q == MODE_OFF);

    assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_OFF) |=> !(perr_q || single_q || dbl_q));

    assert_parity_no_edac_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_PAR) |=> !(single_q || dbl_q));

    assert_edac_no_parity_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_EDAC) |=> !perr_q);

endmodule

// File: rtl/mem_err_detect.sv
module mem_err_detect
    import med_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int HAM_W  = med_pkg::ham_bits(DATA_W),
    localparam int CHK_W  = HAM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_odd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CHK_W-1:0]  wr_check,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_check,
    output logic              mem_err_pin,
    output logic              single_err
);

    med_mode_e        mode;
    logic             odd;
    logic             perr_q;
    logic             single_q;
    logic             dbl_q;
    logic [HAM_W-1:0] wr_ham;
    logic [HAM_W-1:0] rd_ham;
    logic [HAM_W-1:0] syndrome;
    logic             par_bad;
    logic             syn_nz;
    logic             ovr_odd;

    med_hamming #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
        .data_i (wr_data),
        .ham_o  (wr_ham)
    );

    med_hamming #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
        .data_i (rd_data),
        .ham_o  (rd_ham)
    );

    assign syndrome = rd_ham ^ rd_check[HAM_W-1:0];
    assign syn_nz   = |syndrome;
    assign ovr_odd  = ^{rd_data, rd_check};
    assign par_bad  = (^{rd_data, rd_check[0]}) != odd;

    // Write check bits follow the current mode
    always_comb begin
        wr_check = '0;
        unique case (mode)
            MODE_OFF:  wr_check = '0;
            MODE_PAR:  wr_check[0] = (^wr_data) ^ odd;
            MODE_EDAC: wr_check = {(^wr_data) ^ (^wr_ham), wr_ham};
            default:   wr_check = '0;
        endcase
    end

    med_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .cfg_odd  (cfg_odd),
        .rd_valid (rd_valid),
        .par_bad  (par_bad),
        .syn_nz   (syn_nz),
        .ovr_odd  (ovr_odd),
        .mode_o   (mode),
        .odd_o    (odd),
        .perr_q   (perr_q),
        .single_q (single_q),
        .dbl_q    (dbl_q)
    );

    // Shared pin: active-low parity error, or active-high RAM disable
    assign mem_err_pin = (mode == MODE_EDAC) ? dbl_q : ~perr_q;
    assign single_err  = single_q;

    assert_off_wrcheck_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> (wr_check == '0));

    assert_parity_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PAR) |-> (wr_check[CHK_W-1:1] == '0));

    assert_edac_even_codeword_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_EDAC) |-> !(^{wr_data, wr_check}));

endmodule

// File: tb/mem_err_detect_tb.sv
module mem_err_detect_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_mode;
    logic        cfg_odd;
    logic [15:0] wr_data;
    logic [5:0]  wr_check;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [5:0]  rd_check;
    logic        mem_err_pin;
    logic        single_err;

    int nchecks = 0;
    int nerrs   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    mem_err_detect u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_mode    (cfg_mode),
        .cfg_odd     (cfg_odd),
        .wr_data     (wr_data),
        .wr_check    (wr_check),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .rd_check    (rd_check),
        .mem_err_pin (mem_err_pin),
        .single_err  (single_err)
    );

    task automatic check(input string req, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerrs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent encoder: build the 21-bit codeword, then fold positions
    function automatic logic [5:0] ref_code(input logic [15:0] d);
        logic [21:1] cw;
        logic [4:0]  h;
        int k;
        cw = '0;
        h  = '0;
        k  = 0;
        for (int p = 1; p <= 21; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 5; b++) begin
            for (int p = 1; p <= 21; p++) begin
                if ((p >> b) & 1) h[b] = h[b] ^ cw[p];
            end
        end
        return {(^d) ^ (^h), h};
    endfunction

    task automatic set_mode(input logic [1:0] m, input logic odd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_odd = odd;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] d, input logic [5:0] c);
        @(negedge clk);
        rd_valid = 1'b1; rd_data = d; rd_check = c;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 pin", mem_err_pin, 1);
        check("R1 single", single_err, 0);
        wr_data = 16'hBEEF; #1;
        check("R1 wr_check", wr_check, 0);
    endtask

    task automatic t_off;
        set_mode(2'b00, 1'b0);
        do_read(16'h1234, 6'h3F);
        check("R3 pin", mem_err_pin, 1);
        check("R3 single", single_err, 0);
        wr_data = 16'h00FF; #1;
        check("R3 wr_check", wr_check, 0);
    endtask

    task automatic t_parity(input logic odd);
        logic [15:0] d;
        set_mode(2'b01, odd);
        d = 16'hA5C3;
        wr_data = d; #1;
        check("R4 parity wr_check", wr_check, {5'b0, (^d) ^ odd});
        wr_data = 16'h0001; #1;
        check("R4 parity wr_check one bit", wr_check, {5'b0, 1'b1 ^ odd});
        check("R9 parity idle", mem_err_pin, 1);
        do_read(d, {5'b10101, (^d) ^ odd});
        check("R5 clean read, upper bits ignored", mem_err_pin, 1);
        do_read(d, {5'b0, ~((^d) ^ odd)});
        check("R5 corrupt read flags", mem_err_pin, 0);
        check("R7 no single in parity", single_err, 0);
        @(negedge clk);
        check("R5 one cycle only", mem_err_pin, 1);
    endtask

    task automatic t_edac;
        logic [15:0] d;
        logic [5:0]  c;
        set_mode(2'b10, 1'b0);
        check("R9 edac idle low", mem_err_pin, 0);
        d = 16'h5A3C;
        wr_data = d; #1;
        check("R6 encode 5A3C", wr_check, ref_code(d));
        wr_data = 16'hFFFF; #1;
        check("R6 encode FFFF", wr_check, ref_code(16'hFFFF));
        wr_data = 16'h8000; #1;
        check("R6 encode 8000", wr_check, ref_code(16'h8000));
        c = ref_code(d);
        do_read(d, c);
        check("R7 clean single", single_err, 0);
        check("R8 clean ramdis", mem_err_pin, 0);
        do_read(d ^ 16'h0400, c);
        check("R7 data flip single", single_err, 1);
        check("R8 data flip no ramdis", mem_err_pin, 0);
        @(negedge clk);
        check("R7 single one cycle", single_err, 0);
        do_read(d, c ^ 6'h04);
        check("R7 hamming bit flip single", single_err, 1);
        do_read(d, c ^ 6'h20);
        check("R7 overall bit flip single", single_err, 1);
        check("R8 overall flip no ramdis", mem_err_pin, 0);
        do_read(d ^ 16'h0011, c);
        check("R8 double ramdis", mem_err_pin, 1);
        check("R8 double not single", single_err, 0);
        @(negedge clk);
        check("R8 ramdis one cycle", mem_err_pin, 0);
        do_read(d ^ 16'h0001, c ^ 6'h01);
        check("R8 data+check double", mem_err_pin, 1);
    endtask

    task automatic t_no_strobe;
        @(negedge clk);
        rd_valid = 1'b0; rd_data = 16'h1111; rd_check = 6'h00;
        @(negedge clk);
        check("R10 no strobe ramdis", mem_err_pin, 0);
        check("R10 no strobe single", single_err, 0);
    endtask

    task automatic t_same_cycle;
        logic [15:0] d;
        d = 16'h0F0F;
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 2'b01; cfg_odd = 1'b0;
        rd_valid = 1'b1; rd_data = d ^ 16'h0003; rd_check = ref_code(d);
        @(negedge clk);
        cfg_we = 1'b0; rd_valid = 1'b0;
        check("R2 read judged under old mode", single_err, 0);
        check("R2 new mode pin level", mem_err_pin, 1);
    endtask

    task automatic t_reserved;
        set_mode(2'b11, 1'b1);
        do_read(16'h0001, 6'h00);
        check("R2 reserved is off pin", mem_err_pin, 1);
        wr_data = 16'h0001; #1;
        check("R2 reserved is off wr_check", wr_check, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerrs++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = 2'b00; cfg_odd = 1'b0;
        wr_data = '0; rd_valid = 1'b0; rd_data = '0; rd_check = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_off;
        t_parity(1'b0);
        t_parity(1'b1);
        t_edac;
        t_no_strobe;
        t_same_cycle;
        t_reserved;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
        $finish;
    end

endmodule